// File: doc/BRIEF.md
# Double-Buffered DMA Channel

A single DMA channel that moves items between a peripheral data register and memory, one item per peripheral request. Each item is one read from the source side followed by one write to the destination side over a simple request/acknowledge bus master port. Software programs the channel through a small register port: a control word, a 16-bit item count, a peripheral address and two memory base addresses. Flags are cleared by writing ones to a clear register.

Each side has its own item size (byte, half-word or word) and its own pointer mode (fixed or stepping by the item size). Every address put on the bus is aligned to its item size. At the end of a block the channel either stops with a zero count, reloads the count and runs again (circular), or reloads and swaps to the other memory base (double buffer). Half-transfer, transfer-complete and transfer-error flags drive a single interrupt line through per-flag enables.

Top module: `dbuf_dma_channel`

Register selects on `cfg_sel`: 0 control, 1 item count, 2 peripheral address, 3 memory base 0, 4 memory base 1, 5 status (read), 6 flag clear (write). Control bits: 0 enable, 1 direction, 2 circular, 3 double buffer, 4 peripheral step, 5 memory step, 7:6 peripheral size, 9:8 memory size, 10 half-transfer irq enable, 11 complete irq enable, 12 error irq enable, 16 current buffer. Status and clear bits: 0 any flag, 1 half, 2 complete, 3 error.

## Requirements
- R1: The count register (select 1) is loaded only while the enable bit (control bit 0) is 0. A write while enabled leaves it unchanged. A read returns the number of items still to move.
- R2: Each peripheral request served moves one item: a read of the source, then a write of the read data to the destination. Direction bit 1 selects peripheral-to-memory when 0 and memory-to-peripheral when 1. The count drops by one when the write is acknowledged.
- R3: When the count reaches zero with circular mode (control bit 2) set, it reloads the last programmed value and the channel keeps serving requests. With circular mode clear, it stays at zero and no further item is moved.
- R4: While the count is zero, no bus request is issued, even when the channel is enabled and the peripheral is requesting.
- R5: Size code 0 is byte, 1 is half-word and 2 is word. A half-word access forces address bit 0 to 0. A word access forces address bits 1:0 to 0. The bus size output carries the size code of the side being accessed.
- R6: When a side's step bit is set, that side's offset grows by the item size in bytes after each item. When the bit is clear, the side stays at its base. Both offsets return to zero on reload, on buffer switch and on a count write.
- R7: With double buffer (control bit 3) set, the count reloads at each block end and the memory side switches between base 0 and base 1. Control bit 16 reads the current buffer (0 = base 0). It is writable only while disabled, and otherwise changes only by this switch.
- R8: Flags are set by hardware and cleared only by writing 1 to the matching clear bit. Clear bit 0 clears all flags. Status bit 0 is the OR of the three flags. A set and a clear of the same flag in the same cycle leave the flag set.
- R9: An error response on either bus phase sets the error flag (status bit 3), clears the enable bit and aborts the item without changing the count.
- R10: The half flag sets when an item leaves the remaining count equal to floor(programmed count / 2). The complete flag sets when it leaves zero.
- R11: `irq` is high exactly when some flag is set together with its interrupt enable bit.
- R12: After reset, every register reads 0, `irq` is low and no bus request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected register |
| per_req | input | 1 | Peripheral request, one item per service |
| bus_req | output | 1 | Bus access pending; held until acknowledged |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_size | output | 2 | Size code of the access |
| bus_addr | output | AW | Aligned access address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Error response, valid with bus_ack |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| irq | output | 1 | Channel interrupt |

## Verification
On every cycle, the assertions check four things. The count only decrements by one, reloads or holds while the channel is enabled. No bus access is made with a zero count. Half-word and word addresses are aligned. Flags hold until cleared, an error response disables the channel, and the buffer bit moves only in double-buffer mode. The bench scenarios are needed for the rest: the exact address and data of each item across sizes, step modes and base switches, the cycle at which the half and complete flags appear, and the reload value. Only the scenarios also show the set-against-clear collision and the interrupt masking.

// File: rtl/dbuf_dma_channel.sv
module dbuf_dma_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          per_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_CNT = 3'd1, SEL_PADR = 3'd2,
                         SEL_M0 = 3'd3, SEL_M1 = 3'd4, SEL_STAT = 3'd5, SEL_CLR = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t state;

  logic en, dir, circ, dbuf, pinc, minc, ie_ht, ie_tc, ie_te, cur;
  logic [1:0] psz, msz;
  logic [CW-1:0] cnt_prog, cnt_rem, cnt_next;
  logic [AW-1:0] padr, m0, m1, p_off, m_off, p_addr, m_addr;
  logic [DW-1:0] data;
  logic f_ht, f_tc, f_te;
  logic [3:0] clr;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input logic [1:0] s);
    case (s)
      2'd0:    return a;
      2'd1:    return {a[AW-1:1], 1'b0};
      default: return {a[AW-1:2], 2'b00};
    endcase
  endfunction

  function automatic logic [AW-1:0] step(input logic [1:0] s);
    case (s)
      2'd0:    return AW'(1);
      2'd1:    return AW'(2);
      default: return AW'(4);
    endcase
  endfunction

  assign p_addr = align(padr + p_off, psz);
  assign m_addr = align((cur ? m1 : m0) + m_off, msz);

  logic use_mem;
  assign use_mem   = (state == S_RD) ? dir : !dir;
  assign bus_req   = state != S_IDLE;
  assign bus_we    = state == S_WR;
  assign bus_addr  = use_mem ? m_addr : p_addr;
  assign bus_size  = use_mem ? msz : psz;
  assign bus_wdata = data;

  logic item_done, bus_fault, blk_end, reload, hit_half, start;
  assign item_done = state == S_WR && bus_ack && !bus_err;
  assign bus_fault = bus_req && bus_ack && bus_err;
  assign cnt_next  = cnt_rem - CW'(1);
  assign blk_end   = item_done && cnt_next == '0;
  assign reload    = blk_end && (circ || dbuf);
  assign hit_half  = item_done && cnt_next == (cnt_prog >> 1);
  assign start     = state == S_IDLE && en && cnt_rem != '0 && per_req;

  logic wr_ctrl, wr_cnt;
  assign wr_ctrl = cfg_we && cfg_sel == SEL_CTRL;
  assign wr_cnt  = cfg_we && cfg_sel == SEL_CNT && !en;
  assign clr     = (cfg_we && cfg_sel == SEL_CLR) ? cfg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, dir, circ, dbuf, pinc, minc, ie_ht, ie_tc, ie_te, cur} <= '0;
      psz <= '0; msz <= '0;
      padr <= '0; m0 <= '0; m1 <= '0;
    end else begin
      if (wr_ctrl) begin
        en    <= cfg_wdata[0];
        dir   <= cfg_wdata[1];
        circ  <= cfg_wdata[2];
        dbuf  <= cfg_wdata[3];
        pinc  <= cfg_wdata[4];
        minc  <= cfg_wdata[5];
        psz   <= cfg_wdata[7:6];
        msz   <= cfg_wdata[9:8];
        ie_ht <= cfg_wdata[10];
        ie_tc <= cfg_wdata[11];
        ie_te <= cfg_wdata[12];
        if (!en) cur <= cfg_wdata[16];
      end
      if (bus_fault) en <= 1'b0;
      if (reload && dbuf) cur <= !cur;
      if (cfg_we && cfg_sel == SEL_PADR) padr <= AW'(cfg_wdata);
      if (cfg_we && cfg_sel == SEL_M0)   m0   <= AW'(cfg_wdata);
      if (cfg_we && cfg_sel == SEL_M1)   m1   <= AW'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prog <= '0; cnt_rem <= '0; p_off <= '0; m_off <= '0;
    end else if (wr_cnt) begin
      cnt_prog <= cfg_wdata[CW-1:0];
      cnt_rem  <= cfg_wdata[CW-1:0];
      p_off <= '0; m_off <= '0;
    end else if (item_done) begin
      cnt_rem <= reload ? cnt_prog : cnt_next;
      p_off   <= reload ? '0 : p_off + (pinc ? step(psz) : '0);
      m_off   <= reload ? '0 : m_off + (minc ? step(msz) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      data  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_RD;
        S_RD: if (bus_ack) begin
          state <= bus_err ? S_IDLE : S_WR;
          data  <= bus_rdata;
        end
        S_WR: if (bus_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ht <= 1'b0; f_tc <= 1'b0; f_te <= 1'b0;
    end else begin
      f_ht <= hit_half  || (f_ht && !(clr[1] || clr[0]));
      f_tc <= blk_end   || (f_tc && !(clr[2] || clr[0]));
      f_te <= bus_fault || (f_te && !(clr[3] || clr[0]));
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_CTRL: cfg_rdata = {15'b0, cur, 3'b0, ie_te, ie_tc, ie_ht, msz, psz,
                             minc, pinc, dbuf, circ, dir, en};
      SEL_CNT:  cfg_rdata = 32'(cnt_rem);
      SEL_PADR: cfg_rdata = 32'(padr);
      SEL_M0:   cfg_rdata = 32'(m0);
      SEL_M1:   cfg_rdata = 32'(m1);
      SEL_STAT: cfg_rdata = {28'b0, f_te, f_tc, f_ht, f_ht | f_tc | f_te};
      default:  cfg_rdata = '0;
    endcase
  end

  assign irq = (f_ht && ie_ht) || (f_tc && ie_tc) || (f_te && ie_te);

  p_cnt_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && cnt_rem != $past(cnt_rem)) |->
      (cnt_rem == $past(cnt_rem) - CW'(1)) || (cnt_rem == cnt_prog));

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cnt_rem != '0);

  p_half_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size == 2'd1) |-> !bus_addr[0]);

  p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size == 2'd2) |-> bus_addr[1:0] == 2'b00);

  p_cur_dbuf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> ($past(dbuf) || !$past(en)));

  p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_tc && !(clr[2] || clr[0])) |=> f_tc);

  p_fault_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> (!en && f_te));
endmodule

// File: tb/tb_dbuf_dma_channel.sv
`timescale 1ns/1ps
module tb_dbuf_dma_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic per_req = 1'b0;
  logic bus_req, bus_we, irq;
  logic [1:0] bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  int total = 0, bad = 0, done = 0, wn = 0, reqs = 0;
  logic err_arm = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] wa [64];
  logic [31:0] wd [64];
  logic [1:0]  ws [64];

  always #10 clk = ~clk;

  dbuf_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .per_req(per_req), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] src_val(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ {a[31:16], 16'h0};
  endfunction

  function automatic logic [31:0] align_b(input logic [31:0] a, input int s);
    if (s == 1) return {a[31:1], 1'b0};
    if (s == 2) return {a[31:2], 2'b00};
    return a;
  endfunction

  function automatic logic [31:0] ctl(input int en, dir, circ, dbuf, pinc, minc, sz,
                                      ieht, ietc, iete, cur);
    return 32'(en) | 32'(dir) << 1 | 32'(circ) << 2 | 32'(dbuf) << 3 | 32'(pinc) << 4 |
           32'(minc) << 5 | 32'(sz) << 6 | 32'(sz) << 8 | 32'(ieht) << 10 |
           32'(ietc) << 11 | 32'(iete) << 12 | 32'(cur) << 16;
  endfunction

  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_ack   = 1'b1;
      bus_err   = err_arm && !bus_we && bus_addr == err_addr;
      bus_rdata = src_val(bus_addr);
      reqs++;
      if (bus_we) begin
        if (wn < 64) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; ws[wn] = bus_size; end
        wn++;
      end
      if (bus_we || bus_err) done++;
    end else begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] v);
    cfg_sel = sel;
    #1;
    v = cfg_rdata;
  endtask

  task automatic do_item(input logic [3:0] clrmask, output bit ok);
    int old = done;
    ok = 0;
    per_req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (done > old) begin
        per_req = 1'b0;
        if (clrmask != 0) begin cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'(clrmask); end
        @(posedge clk); #1;
        cfg_we = 1'b0;
        ok = 1;
        break;
      end
    end
    per_req = 1'b0;
  endtask

  task automatic run_cfg(input string tag, input int n, items, dir, circ, dbuf, pinc, minc,
                         sz, input logic [31:0] pa, m0a, m1a, input int cur0);
    logic [31:0] v, base, ep, em, src, dst;
    int cur, ht, tc, expc, k, rem;
    bit ok;
    wr_reg(3'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr_reg(3'd1, 32'(n));
    wr_reg(3'd2, pa);
    wr_reg(3'd3, m0a);
    wr_reg(3'd4, m1a);
    wr_reg(3'd6, 32'hF);
    wr_reg(3'd0, ctl(1, dir, circ, dbuf, pinc, minc, sz, 0, 0, 0, cur0));
    wn = 0; cur = cur0; ht = 0; tc = 0;
    for (int it = 0; it < items; it++) begin
      k = it % n;
      do_item(4'h0, ok);
      check(32'(ok), 1, {tag, " R2 item served"});
      base = cur ? m1a : m0a;
      ep = align_b(pa + (pinc ? 32'(k << sz) : 0), sz);
      em = align_b(base + (minc ? 32'(k << sz) : 0), sz);
      src = dir ? em : ep;
      dst = dir ? ep : em;
      check(wa[it], dst, {tag, " R5 R6 destination address"});
      check(wd[it], src_val(src), {tag, " R2 data from source"});
      check(32'(ws[it]), 32'(sz), {tag, " R5 bus size"});
      rem = n - k - 1;
      if (rem == n / 2) ht = 1;
      if (rem == 0) begin
        tc = 1;
        expc = (circ || dbuf) ? n : 0;
        if (dbuf) cur ^= 1;
      end else expc = rem;
      rd_reg(3'd1, v);
      check(v, 32'(expc), {tag, " R1 R3 remaining count"});
      rd_reg(3'd5, v);
      check(32'(v[1]), 32'(ht), {tag, " R10 half flag"});
      check(32'(v[2]), 32'(tc), {tag, " R10 complete flag"});
      rd_reg(3'd0, v);
      check(32'(v[16]), 32'(cur), {tag, " R7 current buffer"});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int r0, w0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 6; s++) begin
      rd_reg(3'(s), v);
      check(v, 0, "R12 register reset value");
    end
    check(32'(irq), 0, "R12 irq after reset");
    check(32'(bus_req), 0, "R12 bus idle after reset");

    wr_reg(3'd0, ctl(1, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0));
    r0 = reqs;
    per_req = 1'b1;
    repeat (12) @(negedge clk);
    per_req = 1'b0;
    check(32'(reqs - r0), 0, "R4 zero count issues no access");
    wr_reg(3'd0, 0);

    run_cfg("word p2m", 4, 4, 0, 0, 0, 0, 1, 2, 32'h4000_0013, 32'h2000_0002, 32'h0, 0);
    wr_reg(3'd1, 32'd9);
    rd_reg(3'd1, v);
    check(v, 0, "R1 count write ignored while enabled");
    w0 = wn;
    do_item(4'h0, ok);
    check(32'(ok), 0, "R3 no service after non-circular end");
    check(32'(wn - w0), 0, "R3 no write after non-circular end");
    check(32'(irq), 0, "R11 irq masked with enables off");
    wr_reg(3'd0, ctl(1, 0, 0, 0, 0, 1, 2, 0, 1, 0, 0));
    #1 check(32'(irq), 1, "R11 irq from complete flag");
    wr_reg(3'd6, 32'h4);
    rd_reg(3'd5, v);
    check(v, 32'h3, "R8 clear complete keeps half and any");
    check(32'(irq), 0, "R11 irq drops after clear");
    wr_reg(3'd6, 32'h1);
    rd_reg(3'd5, v);
    check(v, 0, "R8 clear-all bit");

    run_cfg("half circ m2p", 3, 7, 1, 1, 0, 1, 1, 1, 32'h4000_1001, 32'h3000_0005, 32'h0, 0);
    run_cfg("byte dbuf", 2, 6, 0, 0, 1, 0, 1, 0, 32'h5000_0007, 32'h0000_1000, 32'h0000_2000, 0);
    run_cfg("word dbuf from 1", 3, 7, 1, 0, 1, 1, 1, 2, 32'h6000_0001, 32'h0000_7003, 32'h0000_8006, 1);

    wr_reg(3'd0, 0);
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd2, 32'h4000_0022);
    wr_reg(3'd3, 32'h2000_0000);
    wr_reg(3'd6, 32'hF);
    err_arm = 1'b1; err_addr = 32'h4000_0020;
    wn = 0;
    wr_reg(3'd0, ctl(1, 0, 0, 0, 0, 1, 2, 0, 0, 1, 0));
    do_item(4'h0, ok);
    err_arm = 1'b0;
    rd_reg(3'd5, v);
    check(32'(v[3]), 1, "R9 error flag set");
    check(32'(v[0]), 1, "R8 any flag follows error");
    rd_reg(3'd0, v);
    check(32'(v[0]), 0, "R9 enable cleared by error");
    rd_reg(3'd1, v);
    check(v, 3, "R9 count unchanged by aborted item");
    check(32'(wn), 0, "R9 no write after read error");
    check(32'(irq), 1, "R11 irq from error flag");

    wr_reg(3'd0, 0);
    wr_reg(3'd1, 32'd1);
    wr_reg(3'd6, 32'hF);
    wr_reg(3'd0, ctl(1, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0));
    do_item(4'h4, ok);
    rd_reg(3'd5, v);
    check(32'(v[2]), 1, "R8 set wins over same-cycle clear");

    for (int r = 0; r < 6; r++) begin
      int n, sz, dir, circ, dbuf;
      n = 1 + int'($urandom % 6);
      sz = int'($urandom % 3);
      dir = int'($urandom % 2);
      circ = int'($urandom % 2);
      dbuf = int'($urandom % 2);
      run_cfg("random", n, (circ || dbuf) ? 2 * n + 1 : n, dir, circ, dbuf,
              int'($urandom % 2), int'($urandom % 2), sz, $urandom, $urandom, $urandom,
              int'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule